// File: doc/BRIEF.md
# Indirect Configuration and IO Access Port

This block sits at the register side of a PCI host bridge. A processor reaches PCI configuration space and PCI IO space through three small windows on a register bus. One window holds a stored target address. The second is a data window that turns each access into a configuration cycle. The third is a data window that turns each access into an IO cycle. The block checks every register access for a legal size and byte offset. It forms the downstream address and byte-lane enables, places the data on the correct byte lanes, and returns read data once the PCI side answers. The PCI bus cycles themselves are handled elsewhere.

Both register-bus sides and the downstream port are valid/ready streams.

- **Register request.** A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- **Register response.** The response is held with stable contents until `rsp_ready` is high.
- **Downstream request.** The downstream request holds every field stable until `dn_ready` is high.
- **Downstream response.** This is a single-cycle `dn_rsp_valid` pulse with no back-pressure.
- **One access at a time.** The port accepts one access at a time. `req_ready` stays low from acceptance until the response handshake.

Register-bus address map, using `req_addr[3:0]`:

| Addresses | Window |
|---|---|
| 0x0-0x3 | stored address |
| 0x4-0x7 | configuration data |
| 0x8-0xB | IO data |
| 0xC-0xF | unmapped |

The low two bits of the address are the byte offset within the window.

Top module: `cfgio_port`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `dn_valid` are 0, and a read of the stored address returns 0.
- R2: `req_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes; code 3 is illegal. The stored-address window accepts only a 4-byte access at address 0x0. Any other access in 0x0-0x3 returns `rsp_err`=1 and leaves the stored value unchanged.
- R3: A read of address 0x0 returns the last value written there, with all 32 bits, including bits [1:0].
- R4: An access to the configuration window issues `dn_is_io`=0. It uses `dn_addr` = {stored[31:2], offset}. The issue is unconditional, whatever the value of stored bit 31.
- R5: An access to the IO window issues `dn_is_io`=1. It uses `dn_addr` = (stored value with bits [1:0] cleared) + offset.
- R6: Legal sizes in both data windows depend on the offset: 1, 2 or 4 bytes at offset 0; 1 or 2 bytes at offset 2; only 1 byte at offsets 1 and 3. An illegal size or offset, or any address 0xC-0xF, gives `rsp_err`=1 and `rsp_rdata`=0, with no downstream request.
- R7: `dn_be` has one bit per byte lane (bit i = lane i = `dn_wdata[8i+7:8i]`). Its bits are set for lanes offset to offset+size-1. Lanes outside the enables, and all lanes on a read, carry zero in `dn_wdata`.
- R8: The configuration window is little-endian. Byte k of the register value maps to lane offset+k, for both writes and reads.
- R9: The IO window is big-endian. The most significant byte of an n-byte value maps to lane offset, and byte k counted from the top maps to lane offset+k. Reads are assembled the same way, zero-extended.
- R10: From acceptance until the response handshake `req_ready` is 0, so at most one access is outstanding.
- R11: A pending response and a pending downstream request keep all their fields stable until their ready input is high. Write responses return `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | register access offered |
| req_ready | output | 1 | port can take an access |
| req_addr | input | 4 | window select [3:2] and byte offset [1:0] |
| req_size | input | 2 | access size code |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | write value, right-aligned |
| rsp_valid | output | 1 | response available |
| rsp_ready | input | 1 | response taken |
| rsp_rdata | output | 32 | read value, right-aligned |
| rsp_err | output | 1 | access rejected |
| dn_valid | output | 1 | downstream cycle requested |
| dn_ready | input | 1 | downstream cycle taken |
| dn_is_io | output | 1 | 1 = IO cycle, 0 = configuration cycle |
| dn_write | output | 1 | downstream write |
| dn_addr | output | 32 | downstream target address |
| dn_be | output | 4 | byte-lane enables |
| dn_wdata | output | 32 | lane-placed write data |
| dn_rsp_valid | input | 1 | downstream completion pulse |
| dn_rsp_rdata | input | 32 | lane-placed read data |

## Verification
The properties assume the following about the downstream side:

- `dn_rsp_valid` pulses only after a downstream request has been taken.
- `dn_rsp_valid` pulses exactly once per taken request.
- Register requests are only presented, and only matter, while `req_ready` is high.

The stimulus respects these assumptions:

- Inputs change only at falling edges.
- The completion pulse is raised one cycle after the `dn_ready` handshake and lasts a single cycle.
- A new access is offered only after the previous response has been taken.
- Ready inputs are stalled for several cycles, which exercises the hold rules.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  // register-bus window selected by req_addr[3:2]
  typedef enum logic [1:0] {
    WIN_ADDR = 2'd0,
    WIN_CFG  = 2'd1,
    WIN_IO   = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RSP
  } st_e;
endpackage

// File: rtl/cfgio_decode.sv
module cfgio_decode
  import cfgio_pkg::*;
#(
  parameter int OW = 2,
  localparam int NB = 1 << OW,
  localparam int RAW = OW + 2
) (
  input  logic [RAW-1:0] addr,
  input  logic [1:0]     size,
  output win_e           win,
  output logic [OW-1:0]  off,
  output logic           err,
  output logic [NB-1:0]  be
);
  logic fits, aligned;

  always_comb begin
    int nb;
    win     = win_e'(addr[RAW-1:OW]);
    off     = addr[OW-1:0];
    nb      = 1 << size;
    fits    = (int'(size) <= OW);
    aligned = ((int'(off) % nb) == 0);
    be      = fits ? NB'(((1 << nb) - 1) << off) : '0;
    case (win)
      WIN_ADDR:        err = !((int'(size) == OW) && (off == '0));
      WIN_CFG, WIN_IO: err = !(fits && aligned);
      default:         err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfgio_lanes.sv
module cfgio_lanes #(
  parameter int OW = 2,
  localparam int NB = 1 << OW,
  localparam int DW = 8 * NB
) (
  input  logic [1:0]    w_size,
  input  logic [OW-1:0] w_off,
  input  logic          w_big,
  input  logic [DW-1:0] w_val,
  output logic [DW-1:0] w_lanes,
  input  logic [1:0]    r_size,
  input  logic [OW-1:0] r_off,
  input  logic          r_big,
  input  logic [DW-1:0] r_lanes,
  output logic [DW-1:0] r_val
);
  // register value (right-aligned) -> bus lanes
  always_comb begin
    int nb;
    nb = 1 << w_size;
    w_lanes = '0;
    for (int k = 0; k < NB; k++) begin
      int lane;
      int src;
      lane = int'(w_off) + k;
      src  = w_big ? (nb - 1 - k) : k;
      if (k < nb && lane < NB) w_lanes[lane*8 +: 8] = w_val[src*8 +: 8];
    end
  end

  // bus lanes -> register value (right-aligned, zero-extended)
  always_comb begin
    int nb;
    nb = 1 << r_size;
    r_val = '0;
    for (int k = 0; k < NB; k++) begin
      int lane;
      int dst;
      lane = int'(r_off) + k;
      dst  = r_big ? (nb - 1 - k) : k;
      if (k < nb && lane < NB) r_val[dst*8 +: 8] = r_lanes[lane*8 +: 8];
    end
  end
endmodule

// File: rtl/cfgio_seq.sv
module cfgio_seq
  import cfgio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic go_dn,
  input  logic dn_ready,
  input  logic dn_rsp_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic dn_valid,
  output logic rsp_valid,
  output logic accept,
  output logic capture
);
  st_e st;

  assign req_ready = (st == ST_IDLE);
  assign dn_valid  = (st == ST_REQ);
  assign rsp_valid = (st == ST_RSP);
  assign accept    = req_valid && req_ready;
  assign capture   = (st == ST_WAIT) && dn_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else begin
      case (st)
        ST_IDLE: if (accept)       st <= go_dn ? ST_REQ : ST_RSP;
        ST_REQ:  if (dn_ready)     st <= ST_WAIT;
        ST_WAIT: if (dn_rsp_valid) st <= ST_RSP;
        ST_RSP:  if (rsp_ready)    st <= ST_IDLE;
        default:                   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgio_port.sv
module cfgio_port
  import cfgio_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB),
  localparam int RAW = OW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [RAW-1:0] req_addr,
  input  logic [1:0]     req_size,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_err,
  output logic           dn_valid,
  input  logic           dn_ready,
  output logic           dn_is_io,
  output logic           dn_write,
  output logic [DW-1:0]  dn_addr,
  output logic [NB-1:0]  dn_be,
  output logic [DW-1:0]  dn_wdata,
  input  logic           dn_rsp_valid,
  input  logic [DW-1:0]  dn_rsp_rdata
);
  win_e          win;
  logic [OW-1:0] off;
  logic          dec_err;
  logic [NB-1:0] be;
  logic          go_dn, accept, capture;
  logic [DW-1:0] w_lanes, r_val;

  // stored address, kept exactly as written
  logic [DW-1:0] caddr_raw;
  logic [DW-1:0] base;

  // access latched at acceptance
  logic          l_io, l_write;
  logic [OW-1:0] l_off;
  logic [1:0]    l_size;
  logic [NB-1:0] l_be;
  logic [DW-1:0] l_wdata;
  logic [DW-1:0] rsp_data;
  logic          rsp_e;

  cfgio_decode #(.OW(OW)) u_dec (
    .addr(req_addr), .size(req_size), .win(win), .off(off), .err(dec_err), .be(be)
  );

  cfgio_lanes #(.OW(OW)) u_lanes (
    .w_size(req_size), .w_off(off), .w_big(win == WIN_IO), .w_val(req_wdata), .w_lanes(w_lanes),
    .r_size(l_size), .r_off(l_off), .r_big(l_io), .r_lanes(dn_rsp_rdata), .r_val(r_val)
  );

  assign go_dn = !dec_err && ((win == WIN_CFG) || (win == WIN_IO));

  cfgio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .go_dn(go_dn),
    .dn_ready(dn_ready), .dn_rsp_valid(dn_rsp_valid), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .dn_valid(dn_valid), .rsp_valid(rsp_valid),
    .accept(accept), .capture(capture)
  );

  // decoding copy: low offset bits forced to zero; no enable bit is checked
  assign base     = {caddr_raw[DW-1:OW], {OW{1'b0}}};
  assign dn_addr  = l_io ? (base + DW'(l_off)) : (base | DW'(l_off));
  assign dn_is_io = l_io;
  assign dn_write = l_write;
  assign dn_be    = l_be;
  assign dn_wdata = l_wdata;
  assign rsp_rdata = rsp_data;
  assign rsp_err   = rsp_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      caddr_raw <= '0;
      l_io      <= 1'b0;
      l_write   <= 1'b0;
      l_off     <= '0;
      l_size    <= '0;
      l_be      <= '0;
      l_wdata   <= '0;
      rsp_data  <= '0;
      rsp_e     <= 1'b0;
    end else if (accept) begin
      l_io    <= (win == WIN_IO);
      l_write <= req_write;
      l_off   <= off;
      l_size  <= req_size;
      l_be    <= be;
      l_wdata <= req_write ? w_lanes : '0;
      rsp_e   <= dec_err;
      rsp_data <= (!dec_err && win == WIN_ADDR && !req_write) ? caddr_raw : '0;
      if (!dec_err && win == WIN_ADDR && req_write) caddr_raw <= req_wdata;
    end else if (capture) begin
      rsp_data <= l_write ? '0 : r_val;
    end
  end
endmodule

// File: rtl/cfgio_port_chk.sv
module cfgio_port_chk #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic          dn_is_io,
  input logic          dn_write,
  input logic [DW-1:0] dn_addr,
  input logic [NB-1:0] dn_be,
  input logic [DW-1:0] dn_wdata
);
  logic [DW-1:0] lane_mask;
  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign lane_mask[i*8 +: 8] = {8{dn_be[i]}};
  end

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid || rsp_valid) |-> !req_ready);

  p_idle_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !dn_valid && !rsp_valid));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_dn_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_be) &&
                                 $stable(dn_wdata) && $stable(dn_write) && $stable(dn_is_io)));

  p_be_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_be[dn_addr[OW-1:0]] &&
                  ((dn_be & ((NB'(1) << dn_addr[OW-1:0]) - NB'(1))) == '0)));

  p_lanes_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ((dn_wdata & ~lane_mask) == '0) && (dn_write || dn_wdata == '0));

  p_dn_not_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready) |=> !rsp_err);
endmodule

bind cfgio_port cfgio_port_chk #(.DW(DW)) u_chk (.*);

// File: tb/cfgio_port_test.sv
module cfgio_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [3:0] req_addr;
  logic [1:0] req_size;
  logic [31:0] req_wdata;
  logic rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic dn_valid, dn_ready, dn_is_io, dn_write, dn_rsp_valid;
  logic [31:0] dn_addr, dn_wdata, dn_rsp_rdata;
  logic [3:0] dn_be;

  cfgio_port #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_is_io(dn_is_io), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit mon_on = 0, exp_busy = 0, exp_dn_ok = 0, done = 0;
  logic [31:0] m_caddr = '0;  // model of stored address

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // per-clock comparison against the model's busy / downstream expectation
  always @(negedge clk) begin
    if (mon_on && rst_n && !done) begin
      chk(req_ready == !exp_busy, "R10 ready vs busy", 32'(req_ready), 32'(!exp_busy));
      if (!exp_dn_ok) chk(!dn_valid, "R6 no downstream request", 32'(dn_valid), 32'h0);
    end
  end

  task automatic access(input logic [3:0] a, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input logic [31:0] dn_rd, input int stall,
                        input string r);
    int off, win, nb;
    bit legal, godn;
    logic [31:0] e_addr, e_wdata, e_rd;
    logic [3:0] e_be;
    off = int'(a[1:0]); win = int'(a[3:2]); nb = 1 << sz;
    if (win == 0) legal = (sz == 2) && (off == 0);
    else if (win == 3) legal = 0;
    else legal = (sz <= 2) && (off % nb == 0);
    godn = legal && (win == 1 || win == 2);
    e_addr = {m_caddr[31:2], 2'b00} + 32'(off);
    e_be = '0; e_wdata = '0; e_rd = '0;
    if (godn) begin
      for (int k = 0; k < nb; k++) begin
        int srcb;
        srcb = (win == 2) ? (nb - 1 - k) : k;
        e_be[off + k] = 1'b1;
        if (wr) e_wdata[(off + k)*8 +: 8] = wd[srcb*8 +: 8];
        else e_rd[srcb*8 +: 8] = dn_rd[(off + k)*8 +: 8];
      end
      if (wr) e_rd = '0;
    end else if (legal && !wr) e_rd = m_caddr;

    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    exp_dn_ok = godn;
    @(posedge clk); #1;
    req_valid = 1'b0; exp_busy = 1'b1;
    if (legal && win == 0 && wr) m_caddr = wd;

    if (godn) begin
      do @(negedge clk); while (!dn_valid);
      chk(dn_addr == e_addr, (win == 2) ? "R5 io address" : "R4 config address", dn_addr, e_addr);
      chk(dn_is_io == (win == 2), "R4 R5 cycle kind", 32'(dn_is_io), 32'(win == 2));
      chk(dn_write == wr, "R4 write flag", 32'(dn_write), 32'(wr));
      chk(dn_be == e_be, "R7 byte enables", 32'(dn_be), 32'(e_be));
      chk(dn_wdata == e_wdata, (win == 2) ? "R9 io write lanes" : "R8 config write lanes", dn_wdata, e_wdata);
      repeat (stall) begin
        @(negedge clk);
        chk(dn_valid && dn_addr == e_addr && dn_wdata == e_wdata, "R11 request held", dn_wdata, e_wdata);
      end
      dn_ready = 1'b1;
      @(posedge clk); #1;
      dn_ready = 1'b0;
      @(negedge clk);
      dn_rsp_valid = 1'b1; dn_rsp_rdata = dn_rd;
      @(posedge clk); #1;
      dn_rsp_valid = 1'b0; dn_rsp_rdata = '0;
    end

    do @(negedge clk); while (!rsp_valid);
    repeat (stall) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == e_rd, "R11 response held", rsp_rdata, e_rd);
    end
    chk(rsp_err == !legal, "R6 error flag", 32'(rsp_err), 32'(!legal));
    chk(rsp_rdata == e_rd, r, rsp_rdata, e_rd);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0; exp_busy = 1'b0; exp_dn_ok = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_size = '0; req_write = 0; req_wdata = '0;
    rsp_ready = 0; dn_ready = 0; dn_rsp_valid = 0; dn_rsp_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid === 1'b0 && dn_valid === 1'b0, "R1 valids low after reset",
        32'({rsp_valid, dn_valid}), 32'h0);
    mon_on = 1;

    access(4'h0, 2'd2, 0, '0, '0, 0, "R1 stored address after reset");
    access(4'h0, 2'd2, 1, 32'h8000_1237, '0, 1, "R2 stored address write");
    access(4'h0, 2'd2, 0, '0, '0, 2, "R3 raw readback");
    access(4'h0, 2'd1, 1, 32'h0000_DEAD, '0, 0, "R2 short write rejected");
    access(4'h2, 2'd2, 1, 32'h1111_1111, '0, 0, "R2 offset write rejected");
    access(4'h1, 2'd0, 1, 32'h0000_0055, '0, 0, "R2 byte write rejected");
    access(4'h0, 2'd2, 0, '0, '0, 0, "R2 R3 value unchanged");

    access(4'h4, 2'd2, 0, '0, 32'h4433_2211, 2, "R8 config word read");
    access(4'h5, 2'd0, 1, 32'h0000_00AB, '0, 0, "R4 config byte write");
    access(4'h6, 2'd1, 1, 32'h0000_BEEF, '0, 3, "R8 config half write");
    access(4'h6, 2'd1, 0, '0, 32'h5566_7788, 0, "R8 config half read");
    access(4'h7, 2'd0, 0, '0, 32'hA1B2_C3D4, 1, "R8 config byte read");

    access(4'h8, 2'd2, 1, 32'h1122_3344, '0, 1, "R9 io word write");
    access(4'h8, 2'd2, 0, '0, 32'hDDCC_BBAA, 0, "R9 io word read");
    access(4'hA, 2'd1, 0, '0, 32'hAABB_CCDD, 2, "R9 io half read");
    access(4'hB, 2'd0, 0, '0, 32'h1234_5678, 0, "R9 io byte read");
    access(4'h9, 2'd0, 1, 32'h0000_00C7, '0, 0, "R9 io byte write");
    access(4'h8, 2'd1, 1, 32'h0000_A55A, '0, 0, "R9 io half write");

    access(4'hA, 2'd2, 0, '0, '0, 0, "R6 io word at offset 2");
    access(4'h9, 2'd1, 0, '0, '0, 1, "R6 io half at offset 1");
    access(4'h4, 2'd3, 1, 32'hFFFF_FFFF, '0, 0, "R6 size code 3");
    access(4'hC, 2'd0, 0, '0, '0, 0, "R6 unmapped address");
    access(4'h6, 2'd2, 1, 32'h0, '0, 0, "R6 config word at offset 2");
    access(4'h7, 2'd1, 0, '0, '0, 0, "R6 config half at offset 3");

    access(4'h0, 2'd2, 1, 32'h0000_00FF, '0, 0, "R2 second address write");
    access(4'h9, 2'd0, 0, '0, 32'h0000_EE00, 0, "R5 io address from cleared copy");
    access(4'h7, 2'd0, 1, 32'h0000_0042, '0, 0, "R4 config address low bits");
    access(4'h0, 2'd2, 0, '0, '0, 0, "R3 readback keeps low bits");

    repeat (3) @(negedge clk);
    done = 1;
    report();
  end
endmodule